// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words (1 sign bit, 8-bit biased exponent, 23 stored fraction bits with a hidden leading one). It returns the 32-bit product and three flags: overflow, underflow and invalid. The sign of the product is formed apart from the magnitude path. The magnitude path adds the two biased exponents and subtracts one bias. It then forms the full 48-bit product of the two 24-bit significands. Because that product is always at least 1 and below 4, a single optional right shift normalizes it. The result is rounded to nearest, with ties going to even, using a round bit and a sticky bit taken from the discarded low half of the product.

Special operands are resolved ahead of the arithmetic result. A NaN operand returns a canonical quiet NaN. Zero times infinity returns a quiet NaN and raises invalid. Infinity times any other non-NaN operand returns a signed infinity. Denormal operands are flushed to zero.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream, through one register stage. An operand pair is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result that is shown with `out_ready` low stays unchanged until it is taken. The flags travel with the result and mean nothing while `out_valid` is low.

Top module: `fp32_mul_stream`

## Requirements
- R1: An operand pair is accepted on a rising edge with `in_valid` and `in_ready` both high. Its result is presented with `out_valid` high from the next edge. `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, the product and the flags hold their values.
- R2: Every result other than a NaN carries as its sign (bit 31) the XOR of the two operand signs.
- R3: For two normal operands (exponent field from 1 to 254), the result exponent is EA + EB - 127, plus one when the 48-bit significand product is 2 or more. The 23 kept fraction bits are rounded to nearest, with ties going to even, using the next bit and the OR of all lower bits.
- R4: When rounding carries out of the fraction, the fraction becomes zero and the exponent is incremented once more.
- R5: A final biased exponent above 254 gives infinity (exponent field 255, fraction 0) with the product sign, and sets `out_ovf`.
- R6: A final biased exponent below 1 gives zero (exponent and fraction 0) with the product sign, and sets `out_unf`.
- R7: A NaN operand (exponent field 255, fraction nonzero) gives 0x7FC00000 with no flag set.
- R8: A zero or denormal operand (exponent field 0) times infinity gives 0x7FC00000 and sets `out_inv`.
- R9: Infinity times a normal operand or infinity gives a signed infinity with no flag set.
- R10: A zero or denormal operand times a normal operand gives a signed zero with no flag set.
- R11: After reset, `out_valid` and all three flags are low. At most one flag is high with any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is offered |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result and flags are valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_prod | output | 32 | Product word |
| out_ovf | output | 1 | Result overflowed to infinity |
| out_unf | output | 1 | Result underflowed to zero |
| out_inv | output | 1 | Zero times infinity was requested |

## Verification
The multiplier is driven with hand-picked pairs and with thousands of pseudo-random pairs, checked against a reference that works on integer arithmetic. The hand-picked pairs separate three kinds of bugs. Products with an exact tie that resolve both up and down expose a missing or wrong tie-to-even rule. A factored pair whose product falls 2^-24 short of 2.0 exposes a missing renormalization after the rounding carry. Exponent-sum edges at 0, 1 and 255 expose off-by-one limits on underflow and overflow. Random pairs are drawn both from a mid-range band of exponents and from raw 32-bit words, so that ordinary normalization, both product ranges and all special-operand combinations appear, under random back-pressure and idle gaps that test the stall-hold and acceptance rules.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  // Operand category after decoding the exponent and fraction fields.
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,  // exponent field 0: zero, or a flushed denormal
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } opnd_cls_e;

  typedef struct packed {
    logic      sgn;
    opnd_cls_e cls;
  } opnd_tag_t;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inv;
  } mul_flags_t;

endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack
  import fmul_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word,
  output opnd_tag_t            tag,
  output logic [EXP_W-1:0]     exp_f,
  output logic [MAN_W:0]       sig
);
  localparam int WORD_W = 1 + EXP_W + MAN_W;

  logic [MAN_W-1:0] frac_f;
  logic             exp_zero;
  logic             exp_full;

  assign exp_f    = word[WORD_W-2 -: EXP_W];
  assign frac_f   = word[MAN_W-1:0];
  assign exp_zero = (exp_f == '0);
  assign exp_full = (exp_f == '1);

  always_comb begin
    tag.sgn = word[WORD_W-1];
    if (exp_zero)          tag.cls = CLS_ZERO;
    else if (!exp_full)    tag.cls = CLS_NORM;
    else if (frac_f == '0) tag.cls = CLS_INF;
    else                   tag.cls = CLS_NAN;
  end

  // The hidden one is inserted only for a normal operand; denormals flush.
  assign sig = {tag.cls == CLS_NORM, (tag.cls == CLS_NORM) ? frac_f : '0};

endmodule

// File: rtl/fmul_sigmul.sv
module fmul_sigmul #(
  parameter int MAN_W = 23
) (
  input  logic [MAN_W:0]   sig_a,
  input  logic [MAN_W:0]   sig_b,
  output logic [MAN_W-1:0] frac_trunc,
  output logic             rnd_bit,
  output logic             stk_bit,
  output logic             prod_hi
);
  localparam int SIG_W  = MAN_W + 1;
  localparam int PROD_W = 2 * SIG_W;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] aligned;

  // Full double-width significand product; the result lies in [1,4).
  assign prod    = PROD_W'(sig_a) * PROD_W'(sig_b);
  assign prod_hi = prod[PROD_W-1];

  // One-place alignment: a product in [2,4) keeps its position,
  // a product in [1,2) is moved up so the leading one is at the same bit.
  assign aligned = prod_hi ? prod : {prod[PROD_W-2:0], 1'b0};

  assign frac_trunc = aligned[PROD_W-2 -: MAN_W];
  assign rnd_bit    = aligned[PROD_W-2-MAN_W];
  assign stk_bit    = |aligned[PROD_W-3-MAN_W:0];

endmodule

// File: rtl/fmul_round.sv
module fmul_round #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W-1:0]         exp_a,
  input  logic [EXP_W-1:0]         exp_b,
  input  logic [MAN_W-1:0]         frac_trunc,
  input  logic                     rnd_bit,
  input  logic                     stk_bit,
  input  logic                     prod_hi,
  output logic signed [EXP_W+1:0]  exp_out,
  output logic [MAN_W-1:0]         frac_out
);
  localparam int EXT_W = EXP_W + 2;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [EXT_W-1:0] BIAS_S = EXT_W'(BIAS);

  logic                    round_up;
  logic [MAN_W:0]          frac_sum;
  logic                    frac_carry;
  logic signed [EXT_W-1:0] exp_sum;

  // Nearest, ties to even: raise when above half, or at half with odd LSB.
  assign round_up   = rnd_bit & (stk_bit | frac_trunc[0]);
  assign frac_sum   = {1'b0, frac_trunc} + {{MAN_W{1'b0}}, round_up};
  assign frac_carry = frac_sum[MAN_W];

  // Biased exponent sum with one bias removed, in a widened signed range.
  assign exp_sum = $signed({2'b00, exp_a}) + $signed({2'b00, exp_b}) - BIAS_S;

  // A carry out of the fraction leaves all fraction bits zero.
  assign exp_out  = exp_sum
                  + $signed({{(EXT_W-1){1'b0}}, prod_hi})
                  + $signed({{(EXT_W-1){1'b0}}, frac_carry});
  assign frac_out = frac_sum[MAN_W-1:0];

endmodule

// File: rtl/fmul_resolve.sv
module fmul_resolve
  import fmul_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  opnd_tag_t                tag_a,
  input  opnd_tag_t                tag_b,
  input  logic signed [EXP_W+1:0]  exp_num,
  input  logic [MAN_W-1:0]         frac_num,
  output logic [EXP_W+MAN_W:0]     result,
  output mul_flags_t               flags
);
  localparam int EXT_W  = EXP_W + 2;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam logic signed [EXT_W-1:0] EXP_TOP = EXT_W'((1 << EXP_W) - 2);
  localparam logic signed [EXT_W-1:0] EXP_MIN = EXT_W'(1);
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic sgn;
  logic any_nan;
  logic any_inf;
  logic any_zero;

  assign sgn      = tag_a.sgn ^ tag_b.sgn;
  assign any_nan  = (tag_a.cls == CLS_NAN)  || (tag_b.cls == CLS_NAN);
  assign any_inf  = (tag_a.cls == CLS_INF)  || (tag_b.cls == CLS_INF);
  assign any_zero = (tag_a.cls == CLS_ZERO) || (tag_b.cls == CLS_ZERO);

  // Special operands take priority over the arithmetic path, in this order.
  always_comb begin
    flags  = '0;
    result = {sgn, exp_num[EXP_W-1:0], frac_num};
    if (any_nan) begin
      result = QNAN;
    end else if (any_inf && any_zero) begin
      result    = QNAN;
      flags.inv = 1'b1;
    end else if (any_inf) begin
      result = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    end else if (any_zero) begin
      result = {sgn, {(WORD_W-1){1'b0}}};
    end else if (exp_num > EXP_TOP) begin
      result    = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      flags.ovf = 1'b1;
    end else if (exp_num < EXP_MIN) begin
      result    = {sgn, {(WORD_W-1){1'b0}}};
      flags.unf = 1'b1;
    end
  end

endmodule

// File: rtl/fp32_mul_stream.sv
module fp32_mul_stream
  import fmul_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [EXP_W+MAN_W:0]   in_a,
  input  logic [EXP_W+MAN_W:0]   in_b,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [EXP_W+MAN_W:0]   out_prod,
  output logic                   out_ovf,
  output logic                   out_unf,
  output logic                   out_inv
);
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int N_OPND = 2;

  logic [WORD_W-1:0] opnd   [N_OPND];
  opnd_tag_t         tag    [N_OPND];
  logic [EXP_W-1:0]  exp_f  [N_OPND];
  logic [MAN_W:0]    sig    [N_OPND];

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_unpack
    fmul_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
      .word  (opnd[gi]),
      .tag   (tag[gi]),
      .exp_f (exp_f[gi]),
      .sig   (sig[gi])
    );
  end

  logic [MAN_W-1:0]        frac_trunc;
  logic                    rnd_bit;
  logic                    stk_bit;
  logic                    prod_hi;
  logic signed [EXP_W+1:0] exp_num;
  logic [MAN_W-1:0]        frac_num;
  logic [WORD_W-1:0]       result;
  mul_flags_t              flags;

  fmul_sigmul #(.MAN_W(MAN_W)) u_sigmul (
    .sig_a      (sig[0]),
    .sig_b      (sig[1]),
    .frac_trunc (frac_trunc),
    .rnd_bit    (rnd_bit),
    .stk_bit    (stk_bit),
    .prod_hi    (prod_hi)
  );

  fmul_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
    .exp_a      (exp_f[0]),
    .exp_b      (exp_f[1]),
    .frac_trunc (frac_trunc),
    .rnd_bit    (rnd_bit),
    .stk_bit    (stk_bit),
    .prod_hi    (prod_hi),
    .exp_out    (exp_num),
    .frac_out   (frac_num)
  );

  fmul_resolve #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_resolve (
    .tag_a    (tag[0]),
    .tag_b    (tag[1]),
    .exp_num  (exp_num),
    .frac_num (frac_num),
    .result   (result),
    .flags    (flags)
  );

  // Single output register stage with pass-through ready.
  logic take_in;
  assign in_ready = !out_valid || out_ready;
  assign take_in  = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
      out_ovf   <= 1'b0;
      out_unf   <= 1'b0;
      out_inv   <= 1'b0;
    end else if (take_in) begin
      out_valid <= 1'b1;
      out_prod  <= result;
      out_ovf   <= flags.ovf;
      out_unf   <= flags.unf;
      out_inv   <= flags.inv;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1: a stalled result holds its value and flags.
  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)
      && $stable({out_ovf, out_unf, out_inv})));

  // R1: an accepted pair is presented on the next edge.
  a_r1_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R11: flags are mutually exclusive.
  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_ovf, out_unf, out_inv}));

  // R5: overflow always comes with an infinity.
  a_r5_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |->
      (out_prod[WORD_W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}}));

  // R6: underflow always comes with a zero.
  a_r6_unf_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unf) |-> (out_prod[WORD_W-2:0] == '0));

  // R8: invalid always comes with the canonical quiet NaN.
  a_r8_inv_is_qnan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inv) |->
      (out_prod == {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}}));

endmodule

// File: tb/sim_fp32_mul_stream.sv
module sim_fp32_mul_stream;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_prod;
  logic        out_ovf, out_unf, out_inv;

  always #10 clk = ~clk;  // 50 MHz

  fp32_mul_stream u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod), .out_ovf(out_ovf), .out_unf(out_unf), .out_inv(out_inv)
  );

  int n_vec  = 0;
  int n_miss = 0;
  logic [31:0] rs = 32'h1234_5678;
  bit stall_on = 1'b0;

  logic [34:0] exp_q [$];
  string       tag_q [$];

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // Reference: {inv, unf, ovf, word}, from integer arithmetic.
  function automatic logic [34:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    int ea = int'(a[30:23]);
    int eb = int'(b[30:23]);
    bit s = a[31] ^ b[31];
    bit na = (ea == 255) && (a[22:0] != 0);
    bit nb = (eb == 255) && (b[22:0] != 0);
    bit ia = (ea == 255) && (a[22:0] == 0);
    bit ib = (eb == 255) && (b[22:0] == 0);
    bit za = (ea == 0);
    bit zb = (eb == 0);
    longint unsigned ma, mb, p, keep, rem, half;
    int sh, e;
    if (na || nb) return {3'b000, 32'h7FC0_0000};
    if ((ia && zb) || (ib && za)) return {3'b100, 32'h7FC0_0000};
    if (ia || ib) return {3'b000, s, 8'hFF, 23'd0};
    if (za || zb) return {3'b000, s, 31'd0};
    ma = longint'(a[22:0]) + (64'd1 << 23);
    mb = longint'(b[22:0]) + (64'd1 << 23);
    p = ma * mb;
    sh = (p >= (64'd1 << 47)) ? 24 : 23;
    e = ea + eb - 127 + (sh - 23);
    keep = p >> sh;
    rem  = p - (keep << sh);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && keep[0])) keep = keep + 1;
    if (keep == (64'd1 << 24)) begin
      keep = keep >> 1;
      e = e + 1;
    end
    if (e > 254) return {3'b001, s, 8'hFF, 23'd0};
    if (e < 1)   return {3'b010, s, 31'd0};
    return {3'b000, s, 8'(e), keep[22:0]};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_miss++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One clock: drive, compare against the model, advance the model.
  task automatic cycle(input bit offer, input logic [31:0] a, input logic [31:0] b,
                       input string tag, output bit taken);
    bit exp_rdy;
    @(negedge clk);
    rs = nxt(rs);
    out_ready = stall_on ? rs[3] : 1'b1;
    in_valid  = offer;
    in_a      = a;
    in_b      = b;
    #1;
    exp_rdy = (exp_q.size() == 0) || out_ready;
    check(in_ready === exp_rdy, "R1 in_ready", 64'(in_ready), 64'(exp_rdy));
    check(out_valid === (exp_q.size() != 0), "R1 out_valid",
          64'(out_valid), 64'(exp_q.size() != 0));
    if (exp_q.size() != 0)
      check({out_inv, out_unf, out_ovf, out_prod} === exp_q[0], tag_q[0],
            64'({out_inv, out_unf, out_ovf, out_prod}), 64'(exp_q[0]));
    if (out_ready && exp_q.size() != 0) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    taken = offer && exp_rdy;
    if (taken) begin
      exp_q.push_back(ref_mul(a, b));
      tag_q.push_back(tag);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input string tag);
    bit taken = 1'b0;
    while (!taken) cycle(1'b1, a, b, tag, taken);
    if (stall_on && rs[7:6] == 2'b00) cycle(1'b0, '0, '0, "idle", taken);
  endtask

  task automatic drain();
    bit t;
    while (exp_q.size() != 0) cycle(1'b0, '0, '0, "drain", t);
  endtask

  function automatic logic [31:0] rnd_operand(input logic [31:0] r1, input logic [31:0] r2);
    case (r2[1:0])
      2'd0:    return r1;
      2'd1:    return {r1[31], 8'(r2[9:2] % 8'd8), r1[22:0]};
      default: return {r1[31], 8'(64 + int'(r2[15:8]) % 127), r1[22:0]};
    endcase
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_miss++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R11 reset out_valid", 64'(out_valid), 64'd0);
    check({out_ovf, out_unf, out_inv} === 3'b000, "R11 reset flags",
          64'({out_ovf, out_unf, out_inv}), 64'd0);
    rst_n = 1'b1;

    // Directed pairs, no back-pressure.
    apply(32'h3FC0_0000, 32'h4000_0000, "R3 1.5x2");
    apply(32'hBE20_0000, 32'h4120_0000, "R2 R3 signed");
    apply(32'hBF74_0A10, 32'h3FC0_1000, "R3 normalize carry");
    apply(32'h3F80_0001, 32'h3FC0_0000, "R3 tie rounds up");
    apply(32'h3F80_0003, 32'h3FC0_0000, "R3 tie stays even");
    apply(32'h3F91_8E00, 32'h3FE1_2000, "R4 round carry");
    apply(32'hBF91_8E00, 32'h3FE1_2000, "R4 R2 round carry neg");
    apply(32'h7F00_0000, 32'h4000_0000, "R5 overflow");
    apply(32'hFF00_0000, 32'h4000_0000, "R5 R2 overflow neg");
    apply(32'h7F7F_FFFF, 32'h3F7F_FFFF, "R5 edge no overflow");
    apply(32'h0080_0000, 32'h3F00_0000, "R6 underflow");
    apply(32'h8080_0000, 32'h3F00_0000, "R6 R2 underflow neg");
    apply(32'h0080_0000, 32'h3F80_0000, "R6 edge no underflow");
    apply(32'h7FC0_0000, 32'h3F80_0000, "R7 qnan");
    apply(32'h3F80_0000, 32'hFF80_0001, "R7 snan");
    apply(32'h7FC0_0001, 32'h0000_0000, "R7 nan x zero");
    apply(32'h0000_0000, 32'h7F80_0000, "R8 zero x inf");
    apply(32'hFF80_0000, 32'h0000_0005, "R8 inf x denormal");
    apply(32'h7F80_0000, 32'hC000_0000, "R9 inf x neg");
    apply(32'hFF80_0000, 32'hFF80_0000, "R9 inf x inf");
    apply(32'h0000_0001, 32'h4000_0000, "R10 denormal flush");
    apply(32'h8000_0000, 32'h3F80_0000, "R10 neg zero");
    drain();

    // Random pairs under random back-pressure and idle gaps.
    stall_on = 1'b1;
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] ra, rb;
      rs = nxt(rs); ra = rs;
      rs = nxt(rs); rb = rs;
      rs = nxt(rs);
      apply(rnd_operand(ra, rs), rnd_operand(rb, {rs[15:0], rs[31:16]}), "R3 random");
    end
    drain();
    summary();
  end

endmodule